// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup

This block keeps a small circular queue of in-flight stores and answers forwarding queries from a load pipeline. Each queue entry holds the store's virtual and physical line address, a per-byte write mask, sixteen bytes of data, and two flags that say whether the address and the data have arrived. Stores are allocated in program order at the tail. Their address and their data arrive later, each through its own write port and in any order. Entries are released in order from the head.

A load presents its virtual address, its physical address, its byte mask and a one-bit-per-entry vector that marks the stores older than itself. The caller computes that vector one stage earlier. In the same cycle the block returns an early forward mask and an early data-not-ready flag. One cycle later it returns the complete answer: the forward mask and data, a replay request with a queue index when an older matching store has no data yet, a replay request with a queue index when an older store has no address yet, and a flush request when the virtual-address hits and the physical-address hits disagree.

The response stage is a two-state machine. RSP_IDLE means no answer is presented and RSP_HOLD means an answer is presented. From either state, a cycle with a valid query moves to RSP_HOLD and a cycle without one moves to RSP_IDLE.

Top module: `sqf_lookup`

## Requirements
- R1: After reset no entry is live, `alloc_ready_o` is 1, `alloc_idx_o` is 0, `rsp_valid_o` is 0 and every response field is 0.
- R2: An allocation is accepted only while fewer than ENTRIES entries are live, and it takes the entry at `alloc_idx_o` (the tail). The tail then advances by one, modulo ENTRIES. A release frees the oldest live entry and is ignored when the queue is empty. A write through the address port or the data port has no effect on an entry that is not live, or on the entry being released in that cycle.
- R3: A store hits a load only if the store is live, is marked older, has a valid address, has at least one byte in common with the load mask, and has a physical address equal to the load's above the low log2(BYTES) offset bits. Forward mask bit j can be 1 only where both the store mask and the load mask have bit j set.
- R4: For each byte, the hitting store nearest the tail supplies the byte, where age runs from the head (oldest) towards the tail. Data lane j is bits 8*j+7..8*j. Lanes whose forward mask bit is 0 read as zero.
- R5: `fast_mask_o` and `fast_data_inv_o` reflect a query in the cycle it is presented. `rsp_valid_o` and the full result appear one clock later, and `rsp_mask_o` equals the early mask of that query.
- R6: When any hitting store (R3) has no valid data, the data-not-ready flag is 1 early and late, and `rsp_data_inv_idx_o` is the index of the youngest such store. Otherwise the index is 0.
- R7: When any live, older store has no valid address, `rsp_addr_inv_o` is 1 and `rsp_addr_inv_idx_o` is the index of the youngest such store. Otherwise the index is 0.
- R8: `rsp_match_inv_o` is 1 when the set of stores hit by virtual line address differs from the set hit by physical line address. Both sets use the conditions of R3.
- R9: In a cycle without a query the early outputs are 0. In the following cycle `rsp_valid_o` and all response fields are 0.
- R10: A forward mask bit is 1 only if the store that supplies that byte (R4) has valid data. An older store's data is never used in its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_i | input | 1 | Allocate a store entry at the tail |
| alloc_ready_o | output | 1 | Queue not full |
| alloc_idx_o | output | PTR_W | Index the next allocation takes |
| dealloc_i | input | 1 | Release the head entry |
| addr_we_i | input | 1 | Address write strobe |
| addr_idx_i | input | PTR_W | Entry written by the address port |
| addr_va_i | input | VA_W | Store virtual address |
| addr_pa_i | input | PA_W | Store physical address |
| addr_mask_i | input | BYTES | Store byte mask |
| data_we_i | input | 1 | Data write strobe |
| data_idx_i | input | PTR_W | Entry written by the data port |
| data_i | input | 8*BYTES | Store data |
| ld_valid_i | input | 1 | Load query valid |
| ld_va_i | input | VA_W | Load virtual address |
| ld_pa_i | input | PA_W | Load physical address |
| ld_mask_i | input | BYTES | Load byte mask |
| ld_older_i | input | ENTRIES | Entries older than the load |
| fast_mask_o | output | BYTES | Early forward mask |
| fast_data_inv_o | output | 1 | Early data-not-ready flag |
| rsp_valid_o | output | 1 | Full response valid |
| rsp_mask_o | output | BYTES | Forward mask |
| rsp_data_o | output | 8*BYTES | Forward data lanes |
| rsp_data_inv_o | output | 1 | Replay: older hit lacks data |
| rsp_data_inv_idx_o | output | PTR_W | Entry lacking data |
| rsp_addr_inv_o | output | 1 | Replay: older store lacks address |
| rsp_addr_inv_idx_o | output | PTR_W | Entry lacking address |
| rsp_match_inv_o | output | 1 | Flush: virtual and physical hits disagree |

## Verification
The assertions take for granted that ENTRIES is a power of two, that reset is held for at least one clock, and that at most one query is presented per cycle. They also assume that nothing changes the queue between a query and its response except the writes made in that same cycle, which the late result does not see. They do not assume that `ld_older_i` is a contiguous run from the head. The stimulus therefore mixes head-anchored runs with arbitrary bit patterns. It writes to free entries on purpose to exercise R2, and it sometimes stores a physical line that differs from the virtual line so that the disagreement in R8 occurs.

// File: rtl/sqf_pkg.sv
package sqf_pkg;

    // Presentation state of the late response stage.
    typedef enum logic [0:0] {
        RSP_IDLE = 1'b0,
        RSP_HOLD = 1'b1
    } rsp_state_e;

    localparam int SQF_BYTE_W = 8;

endpackage

// File: rtl/sqf_entry_array.sv
module sqf_entry_array #(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 40,
    parameter int PA_W    = 36,
    parameter int BYTES   = 16,
    localparam int PTR_W  = $clog2(ENTRIES),
    localparam int OFS_W  = $clog2(BYTES),
    localparam int VL_W   = VA_W - OFS_W,
    localparam int PL_W   = PA_W - OFS_W,
    localparam int DATA_W = sqf_pkg::SQF_BYTE_W * BYTES
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              alloc_i,
    input  logic                              dealloc_i,
    input  logic                              addr_we_i,
    input  logic [PTR_W-1:0]                  addr_idx_i,
    input  logic [VL_W-1:0]                   addr_vl_i,
    input  logic [PL_W-1:0]                   addr_pl_i,
    input  logic [BYTES-1:0]                  addr_mask_i,
    input  logic                              data_we_i,
    input  logic [PTR_W-1:0]                  data_idx_i,
    input  logic [DATA_W-1:0]                 data_i,
    output logic [ENTRIES-1:0]                live_o,
    output logic [ENTRIES-1:0]                addr_ok_o,
    output logic [ENTRIES-1:0]                data_ok_o,
    output logic [ENTRIES-1:0][VL_W-1:0]      vline_o,
    output logic [ENTRIES-1:0][PL_W-1:0]      pline_o,
    output logic [ENTRIES-1:0][BYTES-1:0]     mask_o,
    output logic [ENTRIES-1:0][DATA_W-1:0]    data_o,
    output logic [PTR_W-1:0]                  head_o,
    output logic [PTR_W-1:0]                  tail_o,
    output logic                              full_o
);

    // Pointers carry one extra wrap bit so that full and empty differ.
    logic [PTR_W:0] head_q;
    logic [PTR_W:0] tail_q;
    logic           empty;
    logic           take_alloc;
    logic           take_free;

    assign head_o = head_q[PTR_W-1:0];
    assign tail_o = tail_q[PTR_W-1:0];
    assign empty  = (head_q == tail_q);
    assign full_o = (head_q[PTR_W-1:0] == tail_q[PTR_W-1:0]) &&
                    (head_q[PTR_W] != tail_q[PTR_W]);

    assign take_alloc = alloc_i && !full_o;
    assign take_free  = dealloc_i && !empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (take_free) begin
                head_q <= head_q + 1'b1;
            end
            if (take_alloc) begin
                tail_q <= tail_q + 1'b1;
            end
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic              live_r;
        logic              aok_r;
        logic              dok_r;
        logic [VL_W-1:0]   vl_r;
        logic [PL_W-1:0]   pl_r;
        logic [BYTES-1:0]  msk_r;
        logic [DATA_W-1:0] dat_r;
        logic              hit_free;
        logic              hit_alloc;
        logic              wr_addr;
        logic              wr_data;

        assign hit_free  = take_free  && (head_q[PTR_W-1:0] == PTR_W'(e));
        assign hit_alloc = take_alloc && (tail_q[PTR_W-1:0] == PTR_W'(e));
        assign wr_addr   = addr_we_i && (addr_idx_i == PTR_W'(e)) && live_r && !hit_free;
        assign wr_data   = data_we_i && (data_idx_i == PTR_W'(e)) && live_r && !hit_free;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_r <= 1'b0;
                aok_r  <= 1'b0;
                dok_r  <= 1'b0;
            end else if (hit_free) begin
                live_r <= 1'b0;
                aok_r  <= 1'b0;
                dok_r  <= 1'b0;
            end else begin
                if (hit_alloc) begin
                    live_r <= 1'b1;
                    aok_r  <= 1'b0;
                    dok_r  <= 1'b0;
                end
                if (wr_addr) begin
                    aok_r <= 1'b1;
                end
                if (wr_data) begin
                    dok_r <= 1'b1;
                end
            end
        end

        // Payload needs no reset: it is qualified by the flags above.
        always_ff @(posedge clk) begin
            if (wr_addr) begin
                vl_r  <= addr_vl_i;
                pl_r  <= addr_pl_i;
                msk_r <= addr_mask_i;
            end
            if (wr_data) begin
                dat_r <= data_i;
            end
        end

        assign live_o[e]    = live_r;
        assign addr_ok_o[e] = aok_r;
        assign data_ok_o[e] = dok_r;
        assign vline_o[e]   = vl_r;
        assign pline_o[e]   = pl_r;
        assign mask_o[e]    = msk_r;
        assign data_o[e]    = dat_r;
    end

endmodule

// File: rtl/sqf_match.sv
module sqf_match #(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 40,
    parameter int PA_W    = 36,
    parameter int BYTES   = 16,
    localparam int PTR_W  = $clog2(ENTRIES),
    localparam int OFS_W  = $clog2(BYTES),
    localparam int VL_W   = VA_W - OFS_W,
    localparam int PL_W   = PA_W - OFS_W,
    localparam int BW     = sqf_pkg::SQF_BYTE_W,
    localparam int DATA_W = BW * BYTES
) (
    input  logic [ENTRIES-1:0]             live_i,
    input  logic [ENTRIES-1:0]             addr_ok_i,
    input  logic [ENTRIES-1:0]             data_ok_i,
    input  logic [ENTRIES-1:0][VL_W-1:0]   vline_i,
    input  logic [ENTRIES-1:0][PL_W-1:0]   pline_i,
    input  logic [ENTRIES-1:0][BYTES-1:0]  mask_i,
    input  logic [ENTRIES-1:0][DATA_W-1:0] data_i,
    input  logic [PTR_W-1:0]               head_i,
    input  logic [VL_W-1:0]                ld_vl_i,
    input  logic [PL_W-1:0]                ld_pl_i,
    input  logic [BYTES-1:0]               ld_mask_i,
    input  logic [ENTRIES-1:0]             ld_older_i,
    output logic [BYTES-1:0]               fwd_mask_o,
    output logic [DATA_W-1:0]              fwd_data_o,
    output logic                           data_inv_o,
    output logic [PTR_W-1:0]               data_inv_idx_o,
    output logic                           addr_inv_o,
    output logic [PTR_W-1:0]               addr_inv_idx_o,
    output logic                           match_inv_o
);

    logic [ENTRIES-1:0] cand;
    logic [ENTRIES-1:0] phit;
    logic [ENTRIES-1:0] vhit;
    logic [ENTRIES-1:0] noaddr;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        logic overlap;
        assign overlap   = |(mask_i[e] & ld_mask_i);
        assign cand[e]   = live_i[e] && ld_older_i[e];
        assign phit[e]   = cand[e] && addr_ok_i[e] && overlap && (pline_i[e] == ld_pl_i);
        assign vhit[e]   = cand[e] && addr_ok_i[e] && overlap && (vline_i[e] == ld_vl_i);
        assign noaddr[e] = cand[e] && !addr_ok_i[e];
    end

    assign match_inv_o = |(phit ^ vhit);

    // Walk entries from oldest to youngest; later (younger) hits override.
    logic [PTR_W-1:0]          pos;
    logic [BYTES-1:0]          good;
    logic [BYTES-1:0][BW-1:0]  pick;

    always_comb begin
        pos            = '0;
        good           = '0;
        pick           = '0;
        data_inv_o     = 1'b0;
        data_inv_idx_o = '0;
        addr_inv_o     = 1'b0;
        addr_inv_idx_o = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            pos = head_i + PTR_W'(k);
            if (phit[pos]) begin
                if (!data_ok_i[pos]) begin
                    data_inv_o     = 1'b1;
                    data_inv_idx_o = pos;
                end
                for (int j = 0; j < BYTES; j++) begin
                    if (mask_i[pos][j] && ld_mask_i[j]) begin
                        good[j] = data_ok_i[pos];
                        pick[j] = data_i[pos][BW*j +: BW];
                    end
                end
            end
            if (noaddr[pos]) begin
                addr_inv_o     = 1'b1;
                addr_inv_idx_o = pos;
            end
        end
    end

    assign fwd_mask_o = good;

    for (genvar j = 0; j < BYTES; j++) begin : g_lane
        assign fwd_data_o[BW*j +: BW] = good[j] ? pick[j] : '0;
    end

endmodule

// File: rtl/sqf_resp_stage.sv
module sqf_resp_stage #(
    parameter int BYTES   = 16,
    parameter int PTR_W   = 4,
    localparam int DATA_W = sqf_pkg::SQF_BYTE_W * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_valid_i,
    input  logic [BYTES-1:0]  q_mask_i,
    input  logic [DATA_W-1:0] q_data_i,
    input  logic              q_dinv_i,
    input  logic [PTR_W-1:0]  q_didx_i,
    input  logic              q_ainv_i,
    input  logic [PTR_W-1:0]  q_aidx_i,
    input  logic              q_minv_i,
    output logic              valid_o,
    output logic [BYTES-1:0]  mask_o,
    output logic [DATA_W-1:0] data_o,
    output logic              dinv_o,
    output logic [PTR_W-1:0]  didx_o,
    output logic              ainv_o,
    output logic [PTR_W-1:0]  aidx_o,
    output logic              minv_o
);

    import sqf_pkg::*;

    rsp_state_e state_q;
    rsp_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: state_d = q_valid_i ? RSP_HOLD : RSP_IDLE;
            RSP_HOLD: state_d = q_valid_i ? RSP_HOLD : RSP_IDLE;
            default:  state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '0;
            data_o <= '0;
            dinv_o <= 1'b0;
            didx_o <= '0;
            ainv_o <= 1'b0;
            aidx_o <= '0;
            minv_o <= 1'b0;
        end else if (q_valid_i) begin
            mask_o <= q_mask_i;
            data_o <= q_data_i;
            dinv_o <= q_dinv_i;
            didx_o <= q_didx_i;
            ainv_o <= q_ainv_i;
            aidx_o <= q_aidx_i;
            minv_o <= q_minv_i;
        end else begin
            mask_o <= '0;
            data_o <= '0;
            dinv_o <= 1'b0;
            didx_o <= '0;
            ainv_o <= 1'b0;
            aidx_o <= '0;
            minv_o <= 1'b0;
        end
    end

    assign valid_o = (state_q == RSP_HOLD);

endmodule

// File: rtl/sqf_lookup.sv
module sqf_lookup #(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 40,
    parameter int PA_W    = 36,
    parameter int BYTES   = 16,
    localparam int PTR_W  = $clog2(ENTRIES),
    localparam int OFS_W  = $clog2(BYTES),
    localparam int VL_W   = VA_W - OFS_W,
    localparam int PL_W   = PA_W - OFS_W,
    localparam int DATA_W = sqf_pkg::SQF_BYTE_W * BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_i,
    output logic               alloc_ready_o,
    output logic [PTR_W-1:0]   alloc_idx_o,
    input  logic               dealloc_i,
    input  logic               addr_we_i,
    input  logic [PTR_W-1:0]   addr_idx_i,
    input  logic [VA_W-1:0]    addr_va_i,
    input  logic [PA_W-1:0]    addr_pa_i,
    input  logic [BYTES-1:0]   addr_mask_i,
    input  logic               data_we_i,
    input  logic [PTR_W-1:0]   data_idx_i,
    input  logic [DATA_W-1:0]  data_i,
    input  logic               ld_valid_i,
    input  logic [VA_W-1:0]    ld_va_i,
    input  logic [PA_W-1:0]    ld_pa_i,
    input  logic [BYTES-1:0]   ld_mask_i,
    input  logic [ENTRIES-1:0] ld_older_i,
    output logic [BYTES-1:0]   fast_mask_o,
    output logic               fast_data_inv_o,
    output logic               rsp_valid_o,
    output logic [BYTES-1:0]   rsp_mask_o,
    output logic [DATA_W-1:0]  rsp_data_o,
    output logic               rsp_data_inv_o,
    output logic [PTR_W-1:0]   rsp_data_inv_idx_o,
    output logic               rsp_addr_inv_o,
    output logic [PTR_W-1:0]   rsp_addr_inv_idx_o,
    output logic               rsp_match_inv_o
);

    logic [ENTRIES-1:0]             live;
    logic [ENTRIES-1:0]             addr_ok;
    logic [ENTRIES-1:0]             data_ok;
    logic [ENTRIES-1:0][VL_W-1:0]   vline;
    logic [ENTRIES-1:0][PL_W-1:0]   pline;
    logic [ENTRIES-1:0][BYTES-1:0]  smask;
    logic [ENTRIES-1:0][DATA_W-1:0] sdata;
    logic [PTR_W-1:0]               head;
    logic [PTR_W-1:0]               tail;
    logic                           full;

    logic [BYTES-1:0]  m_mask;
    logic [DATA_W-1:0] m_data;
    logic              m_dinv;
    logic [PTR_W-1:0]  m_didx;
    logic              m_ainv;
    logic [PTR_W-1:0]  m_aidx;
    logic              m_minv;

    // Offset bits inside a line take no part in matching.
    logic unused_ofs;
    assign unused_ofs = ^{addr_va_i[OFS_W-1:0], addr_pa_i[OFS_W-1:0],
                          ld_va_i[OFS_W-1:0], ld_pa_i[OFS_W-1:0]};

    sqf_entry_array #(
        .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .BYTES(BYTES)
    ) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_i     (alloc_i),
        .dealloc_i   (dealloc_i),
        .addr_we_i   (addr_we_i),
        .addr_idx_i  (addr_idx_i),
        .addr_vl_i   (addr_va_i[VA_W-1:OFS_W]),
        .addr_pl_i   (addr_pa_i[PA_W-1:OFS_W]),
        .addr_mask_i (addr_mask_i),
        .data_we_i   (data_we_i),
        .data_idx_i  (data_idx_i),
        .data_i      (data_i),
        .live_o      (live),
        .addr_ok_o   (addr_ok),
        .data_ok_o   (data_ok),
        .vline_o     (vline),
        .pline_o     (pline),
        .mask_o      (smask),
        .data_o      (sdata),
        .head_o      (head),
        .tail_o      (tail),
        .full_o      (full)
    );

    sqf_match #(
        .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .BYTES(BYTES)
    ) u_match (
        .live_i         (live),
        .addr_ok_i      (addr_ok),
        .data_ok_i      (data_ok),
        .vline_i        (vline),
        .pline_i        (pline),
        .mask_i         (smask),
        .data_i         (sdata),
        .head_i         (head),
        .ld_vl_i        (ld_va_i[VA_W-1:OFS_W]),
        .ld_pl_i        (ld_pa_i[PA_W-1:OFS_W]),
        .ld_mask_i      (ld_mask_i),
        .ld_older_i     (ld_older_i),
        .fwd_mask_o     (m_mask),
        .fwd_data_o     (m_data),
        .data_inv_o     (m_dinv),
        .data_inv_idx_o (m_didx),
        .addr_inv_o     (m_ainv),
        .addr_inv_idx_o (m_aidx),
        .match_inv_o    (m_minv)
    );

    sqf_resp_stage #(
        .BYTES(BYTES), .PTR_W(PTR_W)
    ) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_valid_i (ld_valid_i),
        .q_mask_i  (m_mask),
        .q_data_i  (m_data),
        .q_dinv_i  (m_dinv),
        .q_didx_i  (m_didx),
        .q_ainv_i  (m_ainv),
        .q_aidx_i  (m_aidx),
        .q_minv_i  (m_minv),
        .valid_o   (rsp_valid_o),
        .mask_o    (rsp_mask_o),
        .data_o    (rsp_data_o),
        .dinv_o    (rsp_data_inv_o),
        .didx_o    (rsp_data_inv_idx_o),
        .ainv_o    (rsp_addr_inv_o),
        .aidx_o    (rsp_addr_inv_idx_o),
        .minv_o    (rsp_match_inv_o)
    );

    assign alloc_ready_o   = !full;
    assign alloc_idx_o     = tail;
    assign fast_mask_o     = ld_valid_i ? m_mask : '0;
    assign fast_data_inv_o = ld_valid_i && m_dinv;

endmodule

// File: rtl/sqf_lookup_chk.sv
module sqf_lookup_chk #(
    parameter int ENTRIES = 16,
    parameter int BYTES   = 16,
    localparam int PTR_W  = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               alloc_ready_o,
    input logic               dealloc_i,
    input logic               ld_valid_i,
    input logic [BYTES-1:0]   ld_mask_i,
    input logic [ENTRIES-1:0] ld_older_i,
    input logic [BYTES-1:0]   fast_mask_o,
    input logic               fast_data_inv_o,
    input logic               rsp_valid_o,
    input logic [BYTES-1:0]   rsp_mask_o,
    input logic               rsp_data_inv_o,
    input logic [PTR_W-1:0]   rsp_data_inv_idx_o,
    input logic               rsp_addr_inv_o,
    input logic [PTR_W-1:0]   rsp_addr_inv_idx_o,
    input logic               rsp_match_inv_o
);

    logic [ENTRIES-1:0] older_q;
    logic [BYTES-1:0]   lmask_q;
    logic [BYTES-1:0]   fmask_q;
    logic               fdinv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older_q <= '0;
            lmask_q <= '0;
            fmask_q <= '0;
            fdinv_q <= 1'b0;
        end else begin
            older_q <= ld_older_i;
            lmask_q <= ld_mask_i;
            fmask_q <= fast_mask_o;
            fdinv_q <= fast_data_inv_o;
        end
    end

    // R5
    rsp_follows_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid_i |=> rsp_valid_o);

    // R9
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid_i |=> (!rsp_valid_o && rsp_mask_o == '0 && !rsp_data_inv_o &&
                         !rsp_addr_inv_o && !rsp_match_inv_o));

    // R9
    fast_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid_i |-> (fast_mask_o == '0 && !fast_data_inv_o));

    // R5
    early_late_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (rsp_mask_o == fmask_q));

    // R6
    early_late_dinv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (rsp_data_inv_o == fdinv_q));

    // R3
    fwd_inside_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> ((rsp_mask_o & ~lmask_q) == '0));

    // R6
    dinv_is_older_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_data_inv_o |-> older_q[rsp_data_inv_idx_o]);

    // R7
    ainv_is_older_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_addr_inv_o |-> older_q[rsp_addr_inv_idx_o]);

    // R2
    full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_ready_o && !dealloc_i) |=> !alloc_ready_o);

endmodule

bind sqf_lookup sqf_lookup_chk #(.ENTRIES(ENTRIES), .BYTES(BYTES)) u_sqf_lookup_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .alloc_ready_o      (alloc_ready_o),
    .dealloc_i          (dealloc_i),
    .ld_valid_i         (ld_valid_i),
    .ld_mask_i          (ld_mask_i),
    .ld_older_i         (ld_older_i),
    .fast_mask_o        (fast_mask_o),
    .fast_data_inv_o    (fast_data_inv_o),
    .rsp_valid_o        (rsp_valid_o),
    .rsp_mask_o         (rsp_mask_o),
    .rsp_data_inv_o     (rsp_data_inv_o),
    .rsp_data_inv_idx_o (rsp_data_inv_idx_o),
    .rsp_addr_inv_o     (rsp_addr_inv_o),
    .rsp_addr_inv_idx_o (rsp_addr_inv_idx_o),
    .rsp_match_inv_o    (rsp_match_inv_o)
);

// File: tb/sqf_lookup_bench.sv
module sqf_lookup_bench;

    localparam int N  = 16;
    localparam int VW = 40;
    localparam int PW = 36;
    localparam int NB = 16;
    localparam int IW = 4;
    localparam int DW = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          alloc_i = 0, dealloc_i = 0, addr_we_i = 0, data_we_i = 0, ld_valid_i = 0;
    logic [IW-1:0] addr_idx_i = '0, data_idx_i = '0;
    logic [VW-1:0] addr_va_i = '0, ld_va_i = '0;
    logic [PW-1:0] addr_pa_i = '0, ld_pa_i = '0;
    logic [NB-1:0] addr_mask_i = '0, ld_mask_i = '0;
    logic [DW-1:0] data_i = '0;
    logic [N-1:0]  ld_older_i = '0;

    logic          alloc_ready_o, fast_data_inv_o, rsp_valid_o;
    logic          rsp_data_inv_o, rsp_addr_inv_o, rsp_match_inv_o;
    logic [IW-1:0] alloc_idx_o, rsp_data_inv_idx_o, rsp_addr_inv_idx_o;
    logic [NB-1:0] fast_mask_o, rsp_mask_o;
    logic [DW-1:0] rsp_data_o;

    sqf_lookup u_sqf_lookup (.*);

    int checks = 0;
    int errors = 0;

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference: arrays and integer pointers.
    bit            m_live[N], m_aok[N], m_dok[N];
    logic [VW-1:0] m_va[N];
    logic [PW-1:0] m_pa[N];
    logic [NB-1:0] m_msk[N];
    logic [DW-1:0] m_dat[N];
    int            m_head = 0, m_count = 0;

    logic [NB-1:0] e_mask;
    logic [DW-1:0] e_data;
    bit            e_dinv, e_ainv, e_minv;
    int            e_didx, e_aidx;

    function automatic bit same_line_v(logic [VW-1:0] a, logic [VW-1:0] b);
        return (a >> 4) == (b >> 4);
    endfunction

    function automatic bit same_line_p(logic [PW-1:0] a, logic [PW-1:0] b);
        return (a >> 4) == (b >> 4);
    endfunction

    task automatic predict;
        bit done[NB];
        bit vh, ph, ov;
        e_mask = '0; e_data = '0;
        e_dinv = 0; e_didx = 0; e_ainv = 0; e_aidx = 0; e_minv = 0;
        foreach (done[j]) done[j] = 0;
        for (int k = N - 1; k >= 0; k--) begin
            int idx = (m_head + k) % N;
            if (!(m_live[idx] && ld_older_i[idx])) continue;
            if (!m_aok[idx]) begin
                if (!e_ainv) begin e_ainv = 1; e_aidx = idx; end
                continue;
            end
            ov = (m_msk[idx] & ld_mask_i) != 0;
            ph = ov && same_line_p(m_pa[idx], ld_pa_i);
            vh = ov && same_line_v(m_va[idx], ld_va_i);
            if (ph != vh) e_minv = 1;
            if (!ph) continue;
            if (!m_dok[idx] && !e_dinv) begin e_dinv = 1; e_didx = idx; end
            for (int j = 0; j < NB; j++) begin
                if (!done[j] && m_msk[idx][j] && ld_mask_i[j]) begin
                    done[j] = 1;
                    if (m_dok[idx]) begin
                        e_mask[j] = 1'b1;
                        e_data[8*j +: 8] = m_dat[idx][8*j +: 8];
                    end
                end
            end
        end
    endtask

    task automatic apply_model;
        bit old_live[N];
        int tl = (m_head + m_count) % N;
        bit fr = dealloc_i && m_count > 0;
        bit al = alloc_i && m_count < N;
        old_live = m_live;
        if (addr_we_i && old_live[addr_idx_i] && !(fr && addr_idx_i == m_head)) begin
            m_aok[addr_idx_i] = 1; m_va[addr_idx_i] = addr_va_i;
            m_pa[addr_idx_i] = addr_pa_i; m_msk[addr_idx_i] = addr_mask_i;
        end
        if (data_we_i && old_live[data_idx_i] && !(fr && data_idx_i == m_head)) begin
            m_dok[data_idx_i] = 1; m_dat[data_idx_i] = data_i;
        end
        if (fr) begin
            m_live[m_head] = 0; m_aok[m_head] = 0; m_dok[m_head] = 0;
            m_head = (m_head + 1) % N; m_count--;
        end
        if (al) begin
            m_live[tl] = 1; m_aok[tl] = 0; m_dok[tl] = 0; m_count++;
        end
    endtask

    // One clock: inputs are set just after a falling edge.
    task automatic tick;
        logic [NB-1:0] p_mask; logic [DW-1:0] p_data;
        bit p_v, p_dinv, p_ainv, p_minv; int p_didx, p_aidx;
        #2;
        predict();
        chk(DW'(alloc_ready_o), DW'(m_count < N), "R2 ready");
        chk(DW'(alloc_idx_o), DW'((m_head + m_count) % N), "R2 tail");
        chk(DW'(fast_mask_o), ld_valid_i ? DW'(e_mask) : '0, "R5 R10 fast mask");
        chk(DW'(fast_data_inv_o), DW'(ld_valid_i && e_dinv), "R6 fast flag");
        p_v = ld_valid_i;
        p_mask = p_v ? e_mask : '0;  p_data = p_v ? e_data : '0;
        p_dinv = p_v && e_dinv;      p_didx = p_v ? e_didx : 0;
        p_ainv = p_v && e_ainv;      p_aidx = p_v ? e_aidx : 0;
        p_minv = p_v && e_minv;
        @(posedge clk);
        apply_model();
        @(negedge clk);
        chk(DW'(rsp_valid_o), DW'(p_v), "R5 R9 valid");
        chk(DW'(rsp_mask_o), DW'(p_mask), "R3 R4 R10 mask");
        chk(rsp_data_o, p_data, "R4 data");
        chk(DW'(rsp_data_inv_o), DW'(p_dinv), "R6 flag");
        chk(DW'(rsp_data_inv_idx_o), DW'(p_didx), "R6 index");
        chk(DW'(rsp_addr_inv_o), DW'(p_ainv), "R7 flag");
        chk(DW'(rsp_addr_inv_idx_o), DW'(p_aidx), "R7 index");
        chk(DW'(rsp_match_inv_o), DW'(p_minv), "R8 flag");
    endtask

    function automatic logic [VW-1:0] va_of(int line);
        return VW'(40'h30_0000_0000) + (VW'(line) << 4) + VW'(5);
    endfunction

    function automatic logic [PW-1:0] pa_of(int line);
        return PW'(36'h8_0000_0000) + (PW'(line) << 4) + PW'(9);
    endfunction

    task automatic idle_in;
        alloc_i = 0; dealloc_i = 0; addr_we_i = 0; data_we_i = 0; ld_valid_i = 0;
    endtask

    task automatic t_alloc;
        alloc_i = 1; tick(); idle_in();
    endtask

    task automatic t_store(int idx, int vl, int pl, logic [NB-1:0] m, bit with_data, logic [7:0] b);
        addr_we_i = 1; addr_idx_i = IW'(idx); addr_va_i = va_of(vl);
        addr_pa_i = pa_of(pl); addr_mask_i = m;
        data_we_i = with_data; data_idx_i = IW'(idx); data_i = {NB{b}};
        tick(); idle_in();
    endtask

    task automatic t_query(int vl, int pl, logic [NB-1:0] m, logic [N-1:0] old);
        ld_valid_i = 1; ld_va_i = va_of(vl); ld_pa_i = pa_of(pl);
        ld_mask_i = m; ld_older_i = old;
        tick(); idle_in();
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        foreach (m_live[i]) begin m_live[i] = 0; m_aok[i] = 0; m_dok[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk(DW'(alloc_ready_o), DW'(1), "R1 ready");
        chk(DW'(alloc_idx_o), DW'(0), "R1 tail");
        chk(DW'(rsp_valid_o), DW'(0), "R1 valid");
        chk(DW'(rsp_mask_o), DW'(0), "R1 mask");
        rst_n = 1;

        // R4: overlapping older stores, youngest supplies each byte
        repeat (4) t_alloc();
        t_store(0, 1, 1, 16'h00FF, 1, 8'h11);
        t_store(1, 1, 1, 16'h0FF0, 1, 8'h22);
        t_store(2, 1, 1, 16'hF000, 1, 8'h33);
        t_store(3, 2, 2, 16'hFFFF, 1, 8'h44);
        t_query(1, 1, 16'hFFFF, 16'h0007);
        t_query(1, 1, 16'h00F0, 16'h0003);
        t_query(2, 2, 16'h0101, 16'h000F);
        t_query(1, 1, 16'hFFFF, 16'h0000);
        // R10 R6: youngest hit lacks data
        t_alloc();
        t_store(4, 1, 1, 16'h000F, 0, 8'h55);
        t_query(1, 1, 16'h00FF, 16'h001F);
        // R7: older store without address
        t_alloc();
        t_query(1, 1, 16'hFFFF, 16'h003F);
        // R8: virtual line hit without physical line hit
        t_store(5, 3, 0, 16'hFFFF, 1, 8'h66);
        t_query(3, 3, 16'hFFFF, 16'h003F);
        // R2: write to a free entry, then fill the queue and overflow it
        t_store(9, 1, 1, 16'hFFFF, 1, 8'h77);
        t_query(1, 1, 16'hFFFF, 16'hFFFF);
        repeat (12) t_alloc();
        // R2: release and wrap around; age follows the head
        repeat (5) begin dealloc_i = 1; tick(); idle_in(); end
        repeat (3) t_alloc();
        t_store(0, 6, 6, 16'hFFFF, 1, 8'hA0);
        t_store(15, 6, 6, 16'h00FF, 1, 8'hB0);
        t_store(1, 6, 6, 16'h0F00, 1, 8'hC0);
        t_query(6, 6, 16'hFFFF, 16'h8003);

        // Mixed traffic
        for (int c = 0; c < 4000; c++) begin
            int ln = $urandom_range(0, 3);
            alloc_i    = ($urandom_range(0, 3) == 0);
            dealloc_i  = ($urandom_range(0, 4) == 0);
            addr_we_i  = ($urandom_range(0, 1) == 0);
            addr_idx_i = IW'($urandom_range(0, N - 1));
            addr_va_i  = va_of(ln);
            addr_pa_i  = pa_of(($urandom_range(0, 9) == 0) ? (ln ^ 1) : ln);
            addr_mask_i = NB'($urandom);
            data_we_i  = ($urandom_range(0, 1) == 0);
            data_idx_i = IW'($urandom_range(0, N - 1));
            data_i     = {$urandom, $urandom, $urandom, $urandom};
            ld_valid_i = ($urandom_range(0, 2) != 0);
            ln         = $urandom_range(0, 3);
            ld_va_i    = va_of(ln);
            ld_pa_i    = pa_of(ln);
            ld_mask_i  = NB'($urandom);
            if ($urandom_range(0, 3) == 0) begin
                ld_older_i = N'($urandom);
            end else begin
                int run = $urandom_range(0, m_count);
                ld_older_i = '0;
                for (int k = 0; k < run; k++) ld_older_i[(m_head + k) % N] = 1'b1;
            end
            tick();
        end
        idle_in();
        tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule